// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block runs the looping byte instructions of an 8-bit processor core. It covers four operations: copying memory to memory, searching memory for a byte equal to the accumulator, reading from a port into memory, and writing from memory to a port. A single start pulse loads the source pointer, the destination pointer, the 16-bit count and the accumulator. The same pulse gives the operation code, a direction flag and a repeat flag.

The block then steps through elements on a synchronous memory port and an I/O port. It updates the pointers and the count as it goes, and it reports a parity/overflow flag and a zero flag. It signals completion with a one-cycle done pulse. The memory and I/O read ports have one cycle of latency: data requested in one cycle is sampled in the next cycle.

The memory operations count down the full 16-bit count. The I/O operations count down only its upper byte. A repeating search stops early on a match.

Top module: `blk_seq`

## Requirements
- R1: `opSel` encodes 0 = copy, 1 = search, 2 = port input, 3 = port output. A `start` seen while idle captures all operands. A `start` seen while `busy` is high is ignored and changes no result.
- R2: Each element takes exactly four cycles: read, transfer/compare, update, test. `done` is high for one cycle, in the test cycle of the last element, so a run of k elements shows `done` in the 4k-th cycle after the start edge. `busy` is high from the cycle after the start edge through that test cycle.
- R3: With `dirDown`=1 the source pointer (and, for copy, the destination pointer) steps by -1 per element. With `dirDown`=0 it steps by +1.
- R4: A copy element reads memory at the source pointer and writes that byte to the destination pointer. The full 16-bit count then decreases by one.
- R5: A search element reads memory at the source pointer and writes nothing. It leaves the destination pointer unchanged and decreases the full count by one.
- R6: A port input element reads the port at the address equal to the full 16-bit count before the decrement. It writes that byte to memory at the source pointer, decreases only the upper byte of the count, and leaves the lower byte unchanged.
- R7: A port output element reads memory at the source pointer and writes that byte to the port. The port address is the full 16-bit count before the decrement, and only the upper byte of the count decreases.
- R8: With `repeatEn`=0 exactly one element runs. With `repeatEn`=1 elements run until the relevant count (full count for memory operations, upper byte for port operations) reaches zero, or, for a search, until the byte read equals the accumulator.
- R9: After each copy or search element, `flagPV` is 1 exactly when the updated full count is not zero. Port elements clear it.
- R10: After each search element, `flagZ` is 1 when the byte read equals the accumulator. After each port element it is 1 when the upper count byte is zero. Copy elements clear it.
- R11: In any cycle at most one of `memRd`, `memWr`, `ioRd`, `ioWr` is high, and none is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| opSel | input | 2 | Operation code |
| dirDown | input | 1 | 1 = pointers decrement |
| repeatEn | input | 1 | 1 = loop until count exhausted |
| srcIn | input | ADDR_W | Initial source pointer |
| dstIn | input | ADDR_W | Initial destination pointer |
| cntIn | input | CNT_W | Initial count |
| accIn | input | DATA_W | Accumulator for search |
| memAddr | output | ADDR_W | Memory address |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write strobe |
| memWData | output | DATA_W | Memory write data |
| memRData | input | DATA_W | Memory read data, one cycle after request |
| ioAddr | output | CNT_W | Port address |
| ioRd | output | 1 | Port read request |
| ioWr | output | 1 | Port write strobe |
| ioWData | output | DATA_W | Port write data |
| ioRData | input | DATA_W | Port read data, one cycle after request |
| srcOut | output | ADDR_W | Current source pointer |
| dstOut | output | ADDR_W | Current destination pointer |
| cntOut | output | CNT_W | Current count |
| flagPV | output | 1 | Parity/overflow flag |
| flagZ | output | 1 | Zero flag |
| busy | output | 1 | Sequencer active |
| done | output | 1 | Final-element pulse |

## Verification
The assertions assume that the external memory and port return read data exactly one cycle after the request. They also assume that a run is never started with a zero value in the count that governs it. A zero count would wrap and run for the whole count range. The stimulus therefore uses only nonzero counts of one, three or five, together with a fixed low byte for port runs. It replies through single-cycle models of the memory and the port. A second start pulse is injected during every run while the block is busy.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_CMP  = 2'd1,
    OP_IN   = 2'd2,
    OP_OUT  = 2'd3
  } blkOp_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_XFER, ST_STEP, ST_TEST
  } seqState_t;

  typedef struct packed {
    logic load;
    logic readPh;
    logic xferPh;
    logic stepPh;
  } seqStrobe_t;
endpackage

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import blk_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastElem,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_READ;
      ST_READ: stateNext = ST_XFER;
      ST_XFER: stateNext = ST_STEP;
      ST_STEP: stateNext = ST_TEST;
      ST_TEST: stateNext = lastElem ? ST_IDLE : ST_READ;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.load   = (state == ST_IDLE) && start;
    stb.readPh = (state == ST_READ);
    stb.xferPh = (state == ST_XFER);
    stb.stepPh = (state == ST_STEP);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_TEST) && lastElem;

  // R2: fixed phase order inside one element
  assert_read_then_xfer_R2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_READ |=> state == ST_XFER);
  assert_xfer_then_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_XFER |=> state == ST_STEP);
  assert_step_then_test_R2: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_STEP |=> state == ST_TEST);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/blk_seq_dp.sv
module blk_seq_dp
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [1:0]        opSel,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [DATA_W-1:0] accIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [CNT_W-1:0]  ioAddr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [DATA_W-1:0] ioWData,
  input  logic [DATA_W-1:0] ioRData,
  output logic [ADDR_W-1:0] srcOut,
  output logic [ADDR_W-1:0] dstOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              flagPV,
  output logic              flagZ,
  output logic              lastElem
);
  localparam int HI_W = CNT_W / 2;
  localparam int LO_W = CNT_W - HI_W;

  blkOp_t            opReg;
  logic              downReg, repReg, matchReg, pvReg, zReg;
  logic [ADDR_W-1:0] srcReg, dstReg, srcStep, dstStep;
  logic [CNT_W-1:0]  cntReg, cntDec;
  logic [DATA_W-1:0] accReg;
  logic [HI_W-1:0]   hiDec;
  logic              isIo, isCopy, isCmp;

  assign isIo   = (opReg == OP_IN) || (opReg == OP_OUT);
  assign isCopy = (opReg == OP_COPY);
  assign isCmp  = (opReg == OP_CMP);

  assign srcStep = downReg ? srcReg - ADDR_W'(1) : srcReg + ADDR_W'(1);
  assign dstStep = downReg ? dstReg - ADDR_W'(1) : dstReg + ADDR_W'(1);
  assign hiDec   = cntReg[CNT_W-1:LO_W] - HI_W'(1);
  assign cntDec  = isIo ? {hiDec, cntReg[LO_W-1:0]} : cntReg - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_COPY;
      downReg  <= 1'b0;
      repReg   <= 1'b0;
      srcReg   <= '0;
      dstReg   <= '0;
      cntReg   <= '0;
      accReg   <= '0;
      matchReg <= 1'b0;
      pvReg    <= 1'b0;
      zReg     <= 1'b0;
    end else if (stb.load) begin
      opReg    <= blkOp_t'(opSel);
      downReg  <= dirDown;
      repReg   <= repeatEn;
      srcReg   <= srcIn;
      dstReg   <= dstIn;
      cntReg   <= cntIn;
      accReg   <= accIn;
      matchReg <= 1'b0;
    end else if (stb.xferPh) begin
      matchReg <= isCmp && (memRData == accReg);
    end else if (stb.stepPh) begin
      srcReg <= srcStep;
      if (isCopy) dstReg <= dstStep;
      cntReg <= cntDec;
      pvReg  <= !isIo && (cntReg != CNT_W'(1));
      zReg   <= isCmp ? matchReg : (isIo && (hiDec == '0));
    end
  end

  // evaluated in the test phase, after the count update
  assign lastElem = !repReg
                 || (isIo ? (cntReg[CNT_W-1:LO_W] == '0) : (cntReg == '0))
                 || (isCmp && matchReg);

  assign memAddr  = (stb.xferPh && isCopy) ? dstReg : srcReg;
  assign memRd    = stb.readPh && (opReg != OP_IN);
  assign ioRd     = stb.readPh && (opReg == OP_IN);
  assign memWr    = stb.xferPh && (isCopy || (opReg == OP_IN));
  assign memWData = isCopy ? memRData : ioRData;
  assign ioWr     = stb.xferPh && (opReg == OP_OUT);
  assign ioWData  = memRData;
  assign ioAddr   = cntReg;

  assign srcOut = srcReg;
  assign dstOut = dstReg;
  assign cntOut = cntReg;
  assign flagPV = pvReg;
  assign flagZ  = zReg;

  // R6: port loops leave the low count byte alone
  assert_lo_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepPh && isIo |=> cntReg[LO_W-1:0] == $past(cntReg[LO_W-1:0]));
  // R5: only copy moves the destination pointer
  assert_dst_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepPh && !isCopy |=> dstReg == $past(dstReg));
  // R5: search never writes memory
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |-> !memWr);
  // R3: source pointer moves by exactly one per element
  assert_src_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepPh |=> (srcReg - $past(srcReg) == ADDR_W'(1))
                 || ($past(srcReg) - srcReg == ADDR_W'(1)));
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opSel,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [DATA_W-1:0] accIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic [CNT_W-1:0]  ioAddr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [DATA_W-1:0] ioWData,
  input  logic [DATA_W-1:0] ioRData,
  output logic [ADDR_W-1:0] srcOut,
  output logic [ADDR_W-1:0] dstOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              flagPV,
  output logic              flagZ,
  output logic              busy,
  output logic              done
);
  seqStrobe_t stb;
  logic       lastElem;

  blk_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastElem(lastElem),
    .stb(stb), .busy(busy), .done(done)
  );

  blk_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opSel(opSel), .dirDown(dirDown),
    .repeatEn(repeatEn), .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn),
    .accIn(accIn), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWData(memWData), .memRData(memRData), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioWr(ioWr), .ioWData(ioWData), .ioRData(ioRData), .srcOut(srcOut),
    .dstOut(dstOut), .cntOut(cntOut), .flagPV(flagPV), .flagZ(flagZ),
    .lastElem(lastElem)
  );

  // R11: a single bus strobe per cycle
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr}));
  // R11: buses quiet while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memRd || memWr || ioRd || ioWr));
endmodule

// File: tb/blk_seq_test.sv
module blk_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        dirDown = 1'b0, repeatEn = 1'b0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  accIn = '0;
  logic [15:0] memAddr, ioAddr, srcOut, dstOut, cntOut;
  logic        memRd, memWr, ioRd, ioWr, flagPV, flagZ, busy, done;
  logic [7:0]  memWData, ioWData;
  logic [7:0]  memRData = '0, ioRData = '0;

  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  blk_seq uut (.*);

  logic [7:0]  mem [0:255];
  logic [15:0] logAddr [0:15];
  logic [7:0]  logData [0:15];
  int          logN = 0;

  function automatic logic [7:0] portFn(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] initByte(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRd) memRData <= mem[memAddr[7:0]];
    if (memWr) mem[memAddr[7:0]] <= memWData;
    if (ioRd) ioRData <= portFn(ioAddr);
    if (ioWr && logN < 16) begin
      logAddr[logN] <= ioAddr;
      logData[logN] <= ioWData;
      logN <= logN + 1;
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stepA(logic [15:0] b, int i, bit dn);
    return dn ? b - 16'(i) : b + 16'(i);
  endfunction

  task automatic runCase(int op, bit dn, bit rep, int n, int accK);
    logic [7:0]  gold [0:255];
    logic [15:0] expLA [0:15];
    logic [7:0]  expLD [0:15];
    logic [15:0] src = 16'h0050, dst = 16'h00B0, cnt, cntE, srcE, dstE;
    logic [7:0]  acc;
    bit io, match = 0, pvE, zE;
    int runN, iter = 0, cyc = 0, bad = 0;
    io = (op >= 2);
    cnt = io ? {8'(n), 8'h37} : 16'(n);
    acc = initByte(int'(stepA(src, accK, dn)));
    for (int i = 0; i < 256; i++) begin
      mem[i] = initByte(i);
      gold[i] = initByte(i);
    end
    logN = 0;
    runN = rep ? n : 1;
    for (int i = 0; i < runN; i++) begin
      logic [15:0] a, b;
      a = stepA(src, i, dn);
      b = io ? {8'(n - i), 8'h37} : cnt - 16'(i);
      iter++;
      case (op)
        0: gold[stepA(dst, i, dn) & 16'hFF] = initByte(int'(a));
        1: match = (initByte(int'(a)) == acc);
        2: gold[a & 16'hFF] = portFn(b);
        default: begin expLA[i] = b; expLD[i] = initByte(int'(a)); end
      endcase
      if (op == 1 && rep && match) break;
    end
    srcE = stepA(src, iter, dn);
    dstE = (op == 0) ? stepA(dst, iter, dn) : dst;
    cntE = io ? {8'(n - iter), 8'h37} : cnt - 16'(iter);
    pvE = !io && (cntE != 0);
    zE = (op == 1) ? match : (io && cntE[15:8] == 0);

    @(negedge clk);
    start = 1; opSel = 2'(op); dirDown = dn; repeatEn = rep;
    srcIn = src; dstIn = dst; cntIn = cnt; accIn = acc;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 200) begin
      if (cyc == 2) begin  // R1: start while busy must be ignored
        start = 1; opSel = 2'(3 - op); dirDown = !dn; srcIn = 16'h0011;
        dstIn = 16'h0022; cntIn = 16'h0909; accIn = ~acc;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    check(cyc == 4 * iter, "R2 cycles", cyc, 4 * iter);
    check(srcOut == srcE, "R3 src", srcOut, srcE);
    check(dstOut == dstE, "R4/R5 dst", dstOut, dstE);
    check(cntOut == cntE, "R8 cnt", cntOut, cntE);
    check(flagPV == pvE, "R9 pv", flagPV, pvE);
    check(flagZ == zE, "R10 z", flagZ, zE);
    @(negedge clk);
    check(!done && !busy, "R2 done single", {done, busy}, 0);
    for (int i = 0; i < 256; i++) if (mem[i] !== gold[i]) bad++;
    check(bad == 0, "R4/R6 memory image", bad, 0);
    if (op == 3) begin
      check(logN == iter, "R7 port writes", logN, iter);
      for (int i = 0; i < iter && i < logN; i++)
        check(logAddr[i] == expLA[i] && logData[i] == expLD[i], "R7 port data",
              {logAddr[i], logData[i]}, {expLA[i], expLD[i]});
    end else check(logN == 0, "R11 no port write", logN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd && !memWr && !ioRd && !ioWr,
          "R11 reset quiet", {busy, done, memRd, memWr, ioRd, ioWr}, 0);
    check(!flagPV && !flagZ, "R1 reset flags", {flagPV, flagZ}, 0);
    rstN = 1;
    @(negedge clk);
    for (int op = 0; op < 4; op++)
      for (int dn = 0; dn < 2; dn++)
        for (int rep = 0; rep < 2; rep++)
          for (int ni = 0; ni < 3; ni++)
            for (int ak = 0; ak < 3; ak += 2)
              runCase(op, dn[0], rep[0], 1 + 2 * ni, ak);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule